// File: doc/BRIEF.md
# Page-Buffered Write Controller with Write Protection

This block is the write side of a 256-byte non-volatile store that is arranged as 16 pages of 16 bytes. A serial front end hands it a word address, then a run of data bytes, and finally a stop event. The controller keeps the bytes in a one-page holding buffer and commits them to the array only when the transaction closes with a stop.

Two protection sources gate the commit, and both are sampled at the stop. A hardware protect input blocks every address. A software protect flag blocks only the lower half of the array. When either one applies, the buffer is dropped and no write cycle begins. A write cycle that does start holds a busy flag for a fixed number of clocks, which is derived from the clock rate and the programming time. The buffered bytes are sent out on a single-byte array write port during the first cycles of that window. Everything the front end presents while busy is high is refused.

Top module: `page_wr_ctrl`

## Requirements
- R1: The byte at position k of a transaction (k = 0, 1, ...) goes to array address {P, (O + k) mod 16}. Here P is bits 7:4 of the loaded word address and O is bits 3:0. The page bits never change inside a transaction.
- R2: Only buffer slots loaded since the last address load are written to the array, and every other byte of the page keeps its old value. When more than 16 bytes arrive, a later byte replaces an earlier byte that has the same offset.
- R3: Nothing is written to the array before the stop. A stop that follows an address load with no data bytes starts no write cycle.
- R4: An accepted stop sets busy_o at the next clock edge. busy_o then stays high for exactly WR_CYCLES = CLK_KHZ * WR_MS clocks. Every array write falls inside that window.
- R5: While busy_o is high, address loads, data bytes and stops are ignored. They do not change the array, and they do not extend or restart busy_o.
- R6: If wp_i is high when the stop is sampled, the buffer is discarded. busy_o stays low and the array is unchanged.
- R7: If sw_prot_i is high at the stop and the page lies in the lower half (address bit 7 = 0), the write is discarded. The same flag has no effect on pages 8 to 15.
- R8: Protection is judged only from the values of wp_i and sw_prot_i during the stop cycle. Their values while the bytes are loaded have no effect.
- R9: While rst_ni is low, busy_o and mem_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Load the word address and open a transaction |
| addr_i | input | 8 | Word address: page in bits 7:4, offset in bits 3:0 |
| byte_valid_i | input | 1 | A data byte is present |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop event that closes the transaction |
| wp_i | input | 1 | Hardware protect for the whole array |
| sw_prot_i | input | 1 | Software protect for addresses 0x00 to 0x7F |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress; new commands are refused |

## Verification
The bench runs transactions on every page. It varies the start offset and sends 1, 3, 16 and 21 bytes, so the pointer wraps inside the page and later bytes replace earlier ones. A design that carries into the page bits would damage the next page. A design that commits the whole page would overwrite bytes that were never loaded.

The bench applies protection in several ways: raised only while the bytes are loaded, raised only at the stop, and the software flag on both halves of the array. A design that samples protection at the wrong moment, or decodes the wrong half, shows up as a mismatch in array contents or in busy. The bench also measures the length of busy exactly. During busy it injects a complete foreign transaction, and any response to that transaction changes the array or stretches busy.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned PAGE_W_DEF = 4;

  // Protection decision taken on the stop cycle.
  function automatic logic prot_block(input logic wp, input logic sw, input logic upper_half);
    return wp | (sw & ~upper_half);
  endfunction
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W,
  localparam int unsigned PNUM_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [PNUM_W-1:0] page_o,
  output logic              any_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_W-1:0]     ptr_q;
  logic [PNUM_W-1:0]     page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
      ptr_q   <= base_i[PAGE_W-1:0];
      page_q  <= base_i[ADDR_W-1:PAGE_W];
    end else if (load_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_q + 1'b1; // wraps inside the page
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i && !clr_i) slot_q[ptr_q] <= data_i;
  end

  assign page_o     = page_q;
  assign any_o      = |valid_q;
  assign rd_data_o  = slot_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];

  p_no_load_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !load_i);
  p_no_clr_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !clr_i);
  p_page_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(page_q));
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit #(
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned WR_CYCLES = 500_000,
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W,
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              scan_o,
  output logic [PAGE_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Buffer slots are drained one per clock at the head of the cycle.
  assign busy_o = busy_q;
  assign scan_o = busy_q && (cnt_q < SCAN_END);
  assign idx_o  = cnt_q[PAGE_W-1:0];

  p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST));
  p_idle_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (cnt_q == '0));
endmodule

// File: rtl/page_wr_ctrl.sv
module page_wr_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned PAGE_W  = PAGE_W_DEF,
  parameter int unsigned CLK_KHZ = 100_000,
  parameter int unsigned WR_MS   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              sw_prot_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o
);
  localparam int unsigned PNUM_W    = ADDR_W - PAGE_W;
  localparam int unsigned WR_CYCLES = CLK_KHZ * WR_MS;

  logic              active_q;
  logic              clr, load, start, blocked, any, rd_valid, scan;
  logic [PNUM_W-1:0] page;
  logic [PAGE_W-1:0] idx;
  logic [DATA_W-1:0] rd_data;

  assign clr     = addr_valid_i && !busy_o;
  assign load    = byte_valid_i && active_q && !clr;
  assign blocked = prot_block(wp_i, sw_prot_i, page[PNUM_W-1]);
  assign start   = stop_i && active_q && !clr && any && !blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (clr)    active_q <= 1'b1;
    else if (stop_i) active_q <= 1'b0;
  end

  pwb_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_buf (
    .clk_i, .rst_ni, .busy_i(busy_o), .clr_i(clr), .base_i(addr_i),
    .load_i(load), .data_i(byte_i), .rd_idx_i(idx), .page_o(page),
    .any_o(any), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  pwb_commit #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_cmt (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy_o), .scan_o(scan), .idx_o(idx)
  );

  assign mem_we_o    = scan && rd_valid;
  assign mem_addr_o  = {page, idx};
  assign mem_wdata_o = rd_data;

  p_wp_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);
  p_sw_lower_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && sw_prot_i && !page[PNUM_W-1] && !busy_o) |=> !busy_o);
  p_busy_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  p_we_in_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
endmodule

// File: tb/test_page_wr_ctrl.sv
`timescale 1ns/1ps
module test_page_wr_ctrl;
  localparam int CLK_KHZ = 4;
  localparam int WR_MS = 5;
  localparam int WRC = CLK_KHZ * WR_MS;

  logic clk = 0, rst_ni = 0;
  logic addr_valid_i = 0, byte_valid_i = 0, stop_i = 0, wp_i = 0, sw_prot_i = 0;
  logic [7:0] addr_i = 0, byte_i = 0;
  logic mem_we_o, busy_o;
  logic [7:0] mem_addr_o, mem_wdata_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] dut_mem [256];
  logic [7:0] exp_mem [256];

  always #5 clk = ~clk;

  page_wr_ctrl #(.CLK_KHZ(CLK_KHZ), .WR_MS(WR_MS)) i_page_wr_ctrl (
    .clk_i(clk), .rst_ni, .addr_valid_i, .addr_i, .byte_valid_i, .byte_i,
    .stop_i, .wp_i, .sw_prot_i, .mem_we_o, .mem_addr_o, .mem_wdata_o, .busy_o
  );

  always @(posedge clk) if (mem_we_o) dut_mem[mem_addr_o] <= mem_wdata_o;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 256; i++) if (dut_mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  // One transaction; optionally inject a foreign transaction while busy.
  task automatic txn(input int page, input int off, input int n, input int seed,
                     input bit wp_load, input bit wp_stop, input bit sw, input bit inject);
    logic [7:0] d [32];
    bit commit;
    int len;
    @(negedge clk);
    addr_valid_i = 1; addr_i = 8'((page << 4) | off); wp_i = wp_load; sw_prot_i = ~sw;
    @(negedge clk);
    addr_valid_i = 0;
    for (int k = 0; k < n; k++) begin
      d[k] = 8'(page * 37 + off * 11 + k * 7 + seed * 3 + 1);
      byte_valid_i = 1; byte_i = d[k];
      @(negedge clk);
    end
    byte_valid_i = 0;
    chk(mem_diff() == 0, "R3 no write before stop", mem_diff(), 0);
    stop_i = 1; wp_i = wp_stop; sw_prot_i = sw;
    @(negedge clk);
    stop_i = 0; wp_i = 0; sw_prot_i = 0;
    commit = (n > 0) && !wp_stop && !(sw && page < 8);
    if (commit)
      for (int k = 0; k < n; k++) exp_mem[(page << 4) | ((off + k) % 16)] = d[k];
    chk(busy_o == commit, "R4 R6 R7 R8 busy after stop", int'(busy_o), int'(commit));
    len = 0;
    while (busy_o && len < 1000) begin
      if (inject && len == 2) begin addr_valid_i = 1; addr_i = 8'(((page + 1) % 16) << 4); end
      if (inject && len == 3) begin addr_valid_i = 0; byte_valid_i = 1; byte_i = 8'hA5; end
      if (inject && len == 4) begin byte_valid_i = 0; stop_i = 1; end
      if (inject && len == 5) stop_i = 0;
      len++;
      @(negedge clk);
    end
    if (commit) chk(len == WRC, "R4 busy length", len, WRC);
    @(negedge clk);
    chk(!busy_o, "R5 busy not restarted", int'(busy_o), 0);
    chk(mem_diff() == 0, "R1 R2 R5 array contents", mem_diff(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dut_mem[i] = 8'(i ^ 8'h5A);
      exp_mem[i] = 8'(i ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_we_o, "R9 reset outputs", int'(busy_o | mem_we_o), 0);
    rst_ni = 1;
    @(negedge clk);
    // Address-only transaction: no cycle.
    txn(3, 5, 0, 0, 0, 0, 0, 0);
    // Sweep all pages with varied offsets, lengths and protection.
    for (int p = 0; p < 16; p++)
      for (int v = 0; v < 4; v++)
        txn(p, (p * 5 + v * 3) % 16, (v == 0) ? 1 : (v == 1) ? 3 : (v == 2) ? 16 : 21,
            p * 4 + v, v == 1, (v == 3) && (p % 4 == 0), v == 2, 0);
    // R8: protect raised only during loading commits; raised only at stop blocks.
    txn(9, 14, 4, 90, 1, 0, 0, 0);
    txn(2, 0, 5, 91, 0, 1, 0, 0);
    // R7: software flag on lower and upper halves.
    txn(7, 15, 2, 92, 0, 0, 1, 0);
    txn(8, 15, 2, 93, 0, 0, 1, 0);
    // R5: foreign transaction while busy.
    txn(5, 6, 7, 94, 0, 0, 0, 1);
    txn(12, 1, 21, 95, 0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule